// File: doc/BRIEF.md
# Masked Data Key Comparator

This block chooses, for every pixel, whether the output stage should take the locally encoded pixel stream or an incoming composite video stream. It watches a 24-bit pixel word split into three 8-bit channels. Each channel is compared with its own 8-bit key value, and any channel can be left out of the comparison. When every channel that takes part matches, a data key is raised. A global enable and an active-video qualifier then gate that data key. The gated data key is ORed with a hardware key pin, which has its own enable.

When the pixel word carries a colour index, an 8-bit mask is ANDed with the index byte before the comparison. The masked word is also passed on, so the lookup stage that follows sees the same index that the comparator saw. The block samples all of its inputs on the pixel load clock. One cycle later it presents a registered select and the registered masked pixel word, and the two stay aligned.

Top module: `dkey_select_top`

## Requirements
- R1: While rst_n is low, and after its release until the first sampled pixel, sel_video_o is 0 and pix_o is all zeros.
- R2: Channel c is bits [8c+7:8c] of pix_i, compared with the same bits of key_val_i. A data-key match needs every enabled channel to compare equal.
- R3: Setting chan_dis_i[c] high removes channel c from the match. A mismatch on a disabled channel does not prevent a data key.
- R4: When all three chan_dis_i bits are high, no data key occurs, whatever the pixel and key values are.
- R5: When dkey_en_i is low, no data key occurs.
- R6: When index_mode_i is high, bits [7:0] of the pixel are ANDed with mask_i before the comparison, and the other bits pass unchanged. When index_mode_i is low, the word is not masked. pix_o carries the word the comparator used.
- R7: When ext_key_i is low, a data key takes effect only while active_i is high. When ext_key_i is high, a data key also takes effect while active_i is low.
- R8: When hw_key_en_i and hw_key_i are both high, sel_video_o is 1, regardless of the data key. When hw_key_en_i is low, hw_key_i has no effect.
- R9: sel_video_o is the OR of the hardware key and the qualified data key. Both sel_video_o and pix_o appear on the clock edge after the edge that sampled the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel load clock |
| rst_n | input | 1 | Active-low reset |
| pix_i | input | 24 | Pixel word, three 8-bit channels |
| index_mode_i | input | 1 | High when the pixel carries a colour index |
| active_i | input | 1 | High during active video |
| hw_key_i | input | 1 | Hardware key pin |
| key_val_i | input | 24 | Key values, one byte per channel |
| chan_dis_i | input | 3 | Per-channel comparator disable |
| dkey_en_i | input | 1 | Data key enable |
| ext_key_i | input | 1 | Allow data keying during blanking |
| hw_key_en_i | input | 1 | Hardware key enable |
| mask_i | input | 8 | Mask for the index byte |
| sel_video_o | output | 1 | Registered select: 1 selects the composite video input |
| pix_o | output | 24 | Registered masked pixel word |

## Verification
The bench builds the block with its default parameters: three 8-bit channels, with the mask on channel 0. This makes every combination of channel disables, both mask modes and all qualifier settings reachable in a short run. The random stimulus often sets the pixel equal to the key and then flips a single channel, so that a true match and a near miss occur often enough to expose any wrong channel being included or left out. Directed cases cover a mask that turns a mismatch into a match, the all-disabled case, keying during blanking with and without the extended bit, and the hardware key overriding a disabled data key.

// File: rtl/dkey_pkg.sv
package dkey_pkg;
    localparam int unsigned CHAN_W    = 8;
    localparam int unsigned NUM_CHAN  = 3;
    localparam int unsigned WORD_W    = CHAN_W * NUM_CHAN;
    localparam int unsigned MASK_CHAN = 0;

    typedef struct packed {
        logic              sel;
        logic [WORD_W-1:0] pix;
    } out_state_t;
endpackage

// File: rtl/dkey_mask.sv
module dkey_mask #(
    parameter int unsigned CHAN_W    = 8,
    parameter int unsigned NUM_CHAN  = 3,
    parameter int unsigned MASK_CHAN = 0,
    localparam int unsigned WORD_W   = CHAN_W * NUM_CHAN
) (
    input  logic [WORD_W-1:0] pix_i,
    input  logic              index_mode_i,
    input  logic [CHAN_W-1:0] mask_i,
    output logic [WORD_W-1:0] pix_o
);
    for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
        if (c == MASK_CHAN) begin : g_masked
            always_comb begin
                pix_o[c*CHAN_W +: CHAN_W] = index_mode_i
                    ? (pix_i[c*CHAN_W +: CHAN_W] & mask_i)
                    : pix_i[c*CHAN_W +: CHAN_W];
            end
        end else begin : g_pass
            always_comb begin
                pix_o[c*CHAN_W +: CHAN_W] = pix_i[c*CHAN_W +: CHAN_W];
            end
        end
    end
endmodule

// File: rtl/dkey_chan_cmp.sv
module dkey_chan_cmp #(
    parameter int unsigned CHAN_W = 8
) (
    input  logic [CHAN_W-1:0] data_i,
    input  logic [CHAN_W-1:0] key_i,
    input  logic              dis_i,
    output logic              eq_o,
    output logic              used_o
);
    always_comb begin
        eq_o   = (data_i == key_i);
        used_o = !dis_i;
    end
endmodule

// File: rtl/dkey_qual.sv
module dkey_qual #(
    parameter int unsigned NUM_CHAN = 3
) (
    input  logic [NUM_CHAN-1:0] eq_i,
    input  logic [NUM_CHAN-1:0] used_i,
    input  logic                dkey_en_i,
    input  logic                ext_key_i,
    input  logic                active_i,
    input  logic                hw_key_en_i,
    input  logic                hw_key_i,
    output logic                sel_o
);
    logic any_used;
    logic all_ok;
    logic window_ok;
    logic data_key;
    logic hw_key;

    always_comb begin
        any_used  = |used_i;
        all_ok    = &(eq_i | ~used_i);
        window_ok = active_i || ext_key_i;
        data_key  = dkey_en_i && any_used && all_ok && window_ok;
        hw_key    = hw_key_en_i && hw_key_i;
        sel_o     = data_key || hw_key;
    end
endmodule

// File: rtl/dkey_select_top.sv
module dkey_select_top
    import dkey_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [23:0]       pix_i,
    input  logic              index_mode_i,
    input  logic              active_i,
    input  logic              hw_key_i,
    input  logic [23:0]       key_val_i,
    input  logic [2:0]        chan_dis_i,
    input  logic              dkey_en_i,
    input  logic              ext_key_i,
    input  logic              hw_key_en_i,
    input  logic [7:0]        mask_i,
    output logic              sel_video_o,
    output logic [23:0]       pix_o
);
    logic [WORD_W-1:0]   masked;
    logic [NUM_CHAN-1:0] chan_eq;
    logic [NUM_CHAN-1:0] chan_used;
    logic                sel_next;
    out_state_t          st_d;
    out_state_t          st_q;

    dkey_mask #(
        .CHAN_W   (CHAN_W),
        .NUM_CHAN (NUM_CHAN),
        .MASK_CHAN(MASK_CHAN)
    ) u_mask (
        .pix_i       (pix_i),
        .index_mode_i(index_mode_i),
        .mask_i      (mask_i),
        .pix_o       (masked)
    );

    for (genvar c = 0; c < NUM_CHAN; c++) begin : g_cmp
        dkey_chan_cmp #(.CHAN_W(CHAN_W)) u_cmp (
            .data_i(masked[c*CHAN_W +: CHAN_W]),
            .key_i (key_val_i[c*CHAN_W +: CHAN_W]),
            .dis_i (chan_dis_i[c]),
            .eq_o  (chan_eq[c]),
            .used_o(chan_used[c])
        );
    end

    dkey_qual #(.NUM_CHAN(NUM_CHAN)) u_qual (
        .eq_i       (chan_eq),
        .used_i     (chan_used),
        .dkey_en_i  (dkey_en_i),
        .ext_key_i  (ext_key_i),
        .active_i   (active_i),
        .hw_key_en_i(hw_key_en_i),
        .hw_key_i   (hw_key_i),
        .sel_o      (sel_next)
    );

    always_comb begin
        st_d     = st_q;
        st_d.sel = sel_next;
        st_d.pix = masked;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sel_video_o = st_q.sel;
    assign pix_o       = st_q.pix;

    // R8: an enabled hardware key selects video on the next edge
    p_hw_key_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_key_en_i && hw_key_i) |=> sel_video_o);

    // R5: data key off and no hardware key gives no selection
    p_dkey_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!dkey_en_i && !(hw_key_en_i && hw_key_i)) |=> !sel_video_o);

    // R4: every channel disabled gives no data key
    p_all_dis_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((chan_dis_i == 3'b111) && !(hw_key_en_i && hw_key_i)) |=> !sel_video_o);

    // R7: blanking without the extended bit gives no data key
    p_blank_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_key_i && !active_i && !(hw_key_en_i && hw_key_i)) |=> !sel_video_o);

    // R6: outside index mode the word passes unmasked
    p_nomask_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !index_mode_i |=> (pix_o == $past(pix_i)));

    // R6: in index mode only the index byte is masked
    p_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
        index_mode_i |=> ((pix_o[23:8] == $past(pix_i[23:8])) &&
                          ((pix_o[7:0] & ~$past(mask_i)) == 8'h00)));
endmodule

// File: tb/dkey_select_top_tb.sv
module dkey_select_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] pix_i = '0;
    logic        index_mode_i = 1'b0;
    logic        active_i = 1'b0;
    logic        hw_key_i = 1'b0;
    logic [23:0] key_val_i = '0;
    logic [2:0]  chan_dis_i = '0;
    logic        dkey_en_i = 1'b0;
    logic        ext_key_i = 1'b0;
    logic        hw_key_en_i = 1'b0;
    logic [7:0]  mask_i = '0;
    logic        sel_video_o;
    logic [23:0] pix_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    dkey_select_top u_dut (
        .clk(clk), .rst_n(rst_n), .pix_i(pix_i), .index_mode_i(index_mode_i),
        .active_i(active_i), .hw_key_i(hw_key_i), .key_val_i(key_val_i),
        .chan_dis_i(chan_dis_i), .dkey_en_i(dkey_en_i), .ext_key_i(ext_key_i),
        .hw_key_en_i(hw_key_en_i), .mask_i(mask_i),
        .sel_video_o(sel_video_o), .pix_o(pix_o)
    );

    function automatic logic [23:0] exp_pix(logic [23:0] p, logic idx, logic [7:0] m);
        return idx ? {p[23:8], p[7:0] & m} : p;
    endfunction

    function automatic logic exp_sel(logic [23:0] p, logic idx, logic [7:0] m,
                                     logic [23:0] k, logic [2:0] dis, logic en,
                                     logic ext, logic act, logic hen, logic hk);
        logic [23:0] w;
        logic ok;
        w  = exp_pix(p, idx, m);
        ok = (dis != 3'b111) && en && (act || ext);
        for (int c = 0; c < 3; c++) begin
            if (!dis[c] && (w[c*8 +: 8] != k[c*8 +: 8])) ok = 1'b0;
        end
        return ok || (hen && hk);
    endfunction

    task automatic check_bit(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s sel actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic check_word(string tag, logic [23:0] act, logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s pix actual=%06h expected=%06h", tag, act, exp);
        end
    endtask

    task automatic step(string tag, logic [23:0] p, logic idx, logic [7:0] m,
                        logic [23:0] k, logic [2:0] dis, logic en, logic ext,
                        logic act, logic hen, logic hk);
        logic es;
        logic [23:0] ep;
        pix_i = p; index_mode_i = idx; mask_i = m; key_val_i = k;
        chan_dis_i = dis; dkey_en_i = en; ext_key_i = ext; active_i = act;
        hw_key_en_i = hen; hw_key_i = hk;
        es = exp_sel(p, idx, m, k, dis, en, ext, act, hen, hk);
        ep = exp_pix(p, idx, m);
        @(posedge clk);
        @(negedge clk);
        check_bit(tag, sel_video_o, es);
        check_word(tag, pix_o, ep);
    endtask

    initial begin
        #4000000;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7719));
        pix_i = 24'hA5A5A5; hw_key_en_i = 1'b1; hw_key_i = 1'b1;
        repeat (3) @(negedge clk);
        check_bit("R1 in reset", sel_video_o, 1'b0);
        check_word("R1 in reset", pix_o, 24'h0);
        rst_n = 1'b1;
        check_bit("R1 after release", sel_video_o, 1'b0);

        step("R2 full match", 24'h123456, 0, 8'h00, 24'h123456, 3'b000, 1, 0, 1, 0, 0);
        step("R2 ch1 mismatch", 24'h123356, 0, 8'h00, 24'h123456, 3'b000, 1, 0, 1, 0, 0);
        step("R2 ch2 mismatch", 24'h133456, 0, 8'h00, 24'h123456, 3'b000, 1, 0, 1, 0, 0);
        step("R3 ch1 disabled", 24'h12FF56, 0, 8'h00, 24'h123456, 3'b010, 1, 0, 1, 0, 0);
        step("R3 ch0 disabled mismatch ch2", 24'h0034FF, 0, 8'h00, 24'h123456, 3'b001, 1, 0, 1, 0, 0);
        step("R4 all disabled", 24'h123456, 0, 8'h00, 24'h123456, 3'b111, 1, 1, 1, 0, 0);
        step("R5 data key off", 24'h123456, 0, 8'h00, 24'h123456, 3'b000, 0, 1, 1, 0, 0);
        step("R6 mask makes match", 24'h1234FF, 1, 8'h0F, 24'h12340F, 3'b000, 1, 0, 1, 0, 0);
        step("R6 no mask outside index", 24'h1234FF, 0, 8'h0F, 24'h12340F, 3'b000, 1, 0, 1, 0, 0);
        step("R6 mask only index byte", 24'hFFFFFF, 1, 8'h3C, 24'h000000, 3'b110, 1, 0, 1, 0, 0);
        step("R7 blanking ext low", 24'h123456, 0, 8'h00, 24'h123456, 3'b000, 1, 0, 0, 0, 0);
        step("R7 blanking ext high", 24'h123456, 0, 8'h00, 24'h123456, 3'b000, 1, 1, 0, 0, 0);
        step("R8 hw key enabled", 24'h000000, 0, 8'h00, 24'h123456, 3'b111, 0, 0, 0, 1, 1);
        step("R8 hw key ignored", 24'h000000, 0, 8'h00, 24'h123456, 3'b000, 1, 0, 1, 0, 1);
        step("R9 or of keys", 24'h123456, 0, 8'h00, 24'h123456, 3'b000, 1, 0, 1, 1, 1);
        step("R9 return to zero", 24'h000001, 0, 8'h00, 24'h123456, 3'b000, 1, 0, 1, 1, 0);

        for (int i = 0; i < 600; i++) begin
            logic [23:0] k, p;
            logic [2:0] flip;
            k = 24'($urandom);
            p = k;
            flip = 3'($urandom_range(0, 4));
            if (flip < 3) p[flip*8 +: 8] = p[flip*8 +: 8] ^ 8'($urandom_range(1, 255));
            step("R9 random", p, 1'($urandom), 8'($urandom), k, 3'($urandom),
                 ($urandom_range(0, 3) != 0), 1'($urandom), 1'($urandom),
                 1'($urandom), ($urandom_range(0, 3) == 0));
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule